// File: doc/BRIEF.md
# Masked Component Register File with Decoder Commit

This block holds the 32-bit control and status words of a memory-expansion component. Software reaches it over a plain register bus that carries a byte address, a write strobe, write data, an access size, and a read-data return. Every stored word has a fixed mask of writable bits. On a write only those bits take the new value, and every other bit keeps what it already held. This is how read-only fields and reset constants stay intact when software writes all ones.

The file groups its words as follows: a capability word that reports how many address decoders exist and which interleave granules they handle, a global decoder control word, six error-reporting words, and a parameterised number of address decoders. Each decoder has base, size, control and target-list words. The block only stores the base, size and target-list values and does no address decoding with them. A write to a decoder control word also runs a commit handshake. The committed flag copies the commit request bit of that write, and the error flag is cleared. A parameter chooses the target-list mask for either an end device or a switch port.

Top module: `memx_regfile`

## Requirements
- R1: Only accesses with `bus_size` = 2'b10 (4 bytes) act. A read with `bus_size` = 2'b11 (8 bytes) returns 0, and a write with that size changes no stored bit. When `bus_valid` is low or the access is a write, `bus_rdata` is 0.
- R2: A 4-byte write stores `(wdata & mask) | (old & ~mask)` into the addressed word. Each word's mask is given in the requirement for that word.
- R3: Each decoder control word resets to 0 and has mask 0x13FF. Bit 9 is the commit request, bit 10 is committed and bit 11 is error. After any write to it, bit 10 equals the stored bit 9 and bit 11 is 0.
- R4: Each decoder's base-low and size-low words have mask 0xF0000000. Its base-high and size-high words have mask 0xFFFFFFFF. All four reset to 0.
- R5: Each decoder's target-high word has mask 0xFFFFFFFF. Its target-low word has mask 0xF0000000 when `TGT_FULL`=0 and 0xFFFFFFFF when `TGT_FULL`=1. Both reset to 0.
- R6: The global decoder control word resets to 0 and has mask 0x3.
- R7: Error words, as (reset, mask): uncorrectable status (0, 0x1CFFF), uncorrectable mask (0x1CFFF, 0x1CFFF), uncorrectable severity (0x1CFFF, 0x1CFFF), correctable status (0, 0x7F), correctable mask (0x7F, 0x7F), and error capability (0x200, 0).
- R8: The capability word is read-only (mask 0). Its fields are: bits [3:0] decoder-count code (1→0, 2→1, 4→2, 6→3, 8→4, 10→5, 12→6, 14→7, 16→8, 20→9, 24→A, 28→B, 32→C), bits [7:4] target count 1, bit 8 the 256-byte granule, and bit 9 the 4 KB granule. With four decoders it reads 0x312.
- R9: Reads of an unmapped word or a reserved word return 0, and writes to those words have no effect.
- R10: The map uses word index = byte address / 4. Index 0 is capability, 1 is global control, 2–4 are uncorrectable status/mask/severity, 5–6 are correctable status/mask, and 7 is error capability. Decoder d occupies indices 8+8d..15+8d in the order base-low, base-high, size-low, size-high, control, target-low, target-high, reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 2'b10 = 4 bytes, 2'b11 = 8 bytes |
| bus_addr | input | ADDR_W | Byte address, 4-byte aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current contents |

## Verification
On a decoder control word, the mask merge and the commit handshake act in the same clock edge. The bench provokes this by writing all ones, which tries to set the read-only committed and error bits while the commit request is also set. It then writes patterns in which the requested committed and error values disagree with the commit request. Each result is judged against the expectation that bit 10 follows the stored bit 9 and bit 11 reads 0, whatever the bus drove on those bits.

// File: rtl/memx_pkg.sv
package memx_pkg;

   localparam int DW         = 32;
   localparam int FIX_WORDS  = 8;
   localparam int DEC_STRIDE = 8;
   localparam int DEC_USED   = 7;

   localparam logic [1:0] SZ_W4 = 2'b10;
   localparam logic [1:0] SZ_W8 = 2'b11;

   // fixed word indices
   localparam int W_CAP    = 0;
   localparam int W_GCTL   = 1;
   localparam int W_UE_STS = 2;
   localparam int W_UE_MSK = 3;
   localparam int W_UE_SEV = 4;
   localparam int W_CE_STS = 5;
   localparam int W_CE_MSK = 6;
   localparam int W_ERRCAP = 7;

   // offsets inside one decoder
   localparam int D_BASE_LO = 0;
   localparam int D_BASE_HI = 1;
   localparam int D_SIZE_LO = 2;
   localparam int D_SIZE_HI = 3;
   localparam int D_CTRL    = 4;
   localparam int D_TGT_LO  = 5;
   localparam int D_TGT_HI  = 6;

   localparam int CTL_COMMIT = 9;
   localparam int CTL_DONE   = 10;
   localparam int CTL_ERR    = 11;
   localparam logic [DW-1:0] CTL_MASK = 32'h0000_13FF;

   localparam logic [DW-1:0] UE_BITS = 32'h0001_CFFF;
   localparam logic [DW-1:0] CE_BITS = 32'h0000_007F;
   localparam logic [DW-1:0] ERRCAP_RST = 32'h0000_0200;
   localparam logic [DW-1:0] ALIGN_MASK = 32'hF000_0000;

   function automatic bit dec_cnt_ok(input int n);
      return (n == 1) || (n >= 2 && n <= 16 && n % 2 == 0) ||
             (n >= 20 && n <= 32 && n % 4 == 0);
   endfunction

   function automatic logic [3:0] dec_cnt_code(input int n);
      int c;
      if (n <= 1)       c = 0;
      else if (n <= 16) c = n / 2;
      else              c = (n - 20) / 4 + 9;
      return 4'(c);
   endfunction

   function automatic logic [DW-1:0] cap_word(input int n);
      logic [DW-1:0] v;
      v        = '0;
      v[3:0]   = dec_cnt_code(n);
      v[7:4]   = 4'd1;
      v[8]     = 1'b1;
      v[9]     = 1'b1;
      return v;
   endfunction

   function automatic logic [DW-1:0] fixed_rst(input int i, input int n);
      case (i)
         W_CAP:              return cap_word(n);
         W_UE_MSK, W_UE_SEV: return UE_BITS;
         W_CE_MSK:           return CE_BITS;
         W_ERRCAP:           return ERRCAP_RST;
         default:            return '0;
      endcase
   endfunction

   function automatic logic [DW-1:0] fixed_mask(input int i);
      case (i)
         W_GCTL:                       return 32'h3;
         W_UE_STS, W_UE_MSK, W_UE_SEV: return UE_BITS;
         W_CE_STS, W_CE_MSK:           return CE_BITS;
         default:                      return '0;
      endcase
   endfunction

   function automatic logic [DW-1:0] dec_mask(input int k, input bit tgt_full);
      case (k)
         D_BASE_LO, D_SIZE_LO: return ALIGN_MASK;
         D_CTRL:               return CTL_MASK;
         D_TGT_LO:             return tgt_full ? '1 : ALIGN_MASK;
         default:              return '1;
      endcase
   endfunction

endpackage

// File: rtl/memx_mask_reg.sv
module memx_mask_reg #(
   parameter int              W    = 32,
   parameter logic [W-1:0]    RST  = '0,
   parameter logic [W-1:0]    MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= (wdata & MASK) | (q & ~MASK);
   end

   generate
      if (MASK != {W{1'b1}}) begin : g_ro_check
         AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((q & ~MASK) == ($past(q) & ~MASK))); // R2
      end
   endgenerate

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R1

endmodule

// File: rtl/memx_dec_ctrl.sv
module memx_dec_ctrl
   import memx_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   logic [DW-1:0] merged;
   logic [DW-1:0] nxt;

   always_comb begin
      merged            = (wdata & CTL_MASK) | (q & ~CTL_MASK);
      nxt               = merged;
      nxt[CTL_DONE]     = merged[CTL_COMMIT];
      nxt[CTL_ERR]      = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
   end

   AST_COMMIT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q[CTL_DONE] == $past(wdata[CTL_COMMIT])) && !q[CTL_ERR]); // R3

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R3

endmodule

// File: rtl/memx_dec_slot.sv
module memx_dec_slot
   import memx_pkg::*;
#(
   parameter bit TGT_FULL = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DEC_USED-1:0]           we,
   input  logic [DW-1:0]                 wdata,
   output logic [DEC_USED-1:0][DW-1:0]   q
);

   generate
      for (genvar k = 0; k < DEC_USED; k++) begin : g_word
         if (k == D_CTRL) begin : g_ctrl
            memx_dec_ctrl u_ctrl (
               .clk   (clk),
               .rst_n (rst_n),
               .we    (we[k]),
               .wdata (wdata),
               .q     (q[k])
            );
         end else begin : g_data
            memx_mask_reg #(
               .W    (DW),
               .RST  ('0),
               .MASK (dec_mask(k, TGT_FULL))
            ) u_reg (
               .clk   (clk),
               .rst_n (rst_n),
               .we    (we[k]),
               .wdata (wdata),
               .q     (q[k])
            );
         end
      end
   endgenerate

endmodule

// File: rtl/memx_regfile.sv
module memx_regfile
   import memx_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_DEC  = 4,
   parameter bit TGT_FULL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata
);

   localparam int IW        = ADDR_W - 2;
   localparam int NUM_WORDS = 1 << IW;
   localparam int DEC_END   = FIX_WORDS + NUM_DEC * DEC_STRIDE;

   generate
      if (!dec_cnt_ok(NUM_DEC)) begin : g_bad_count
         $error("NUM_DEC has no capability encoding");
      end
      if (DEC_END > NUM_WORDS) begin : g_bad_addr
         $error("ADDR_W too small for NUM_DEC decoders");
      end
   endgenerate

   logic [IW-1:0] idx;
   logic          wr4;
   logic          rd4;
   logic          unused_lo;

   assign idx       = bus_addr[ADDR_W-1:2];
   assign unused_lo = ^bus_addr[1:0];
   assign wr4       = bus_valid && bus_write  && (bus_size == SZ_W4);
   assign rd4       = bus_valid && !bus_write && (bus_size == SZ_W4);

   logic [DW-1:0]               fix_q [FIX_WORDS];
   logic [DEC_USED-1:0][DW-1:0] dec_q [NUM_DEC];
   logic [DW-1:0]               word_arr [NUM_WORDS];

   // fixed words: capability, global control, error block
   generate
      for (genvar f = 0; f < FIX_WORDS; f++) begin : g_fix
         memx_mask_reg #(
            .W    (DW),
            .RST  (fixed_rst(f, NUM_DEC)),
            .MASK (fixed_mask(f))
         ) u_fix (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr4 && (idx == IW'(f))),
            .wdata (bus_wdata),
            .q     (fix_q[f])
         );
      end
   endgenerate

   // decoders
   generate
      for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
         logic [DEC_USED-1:0] dwe;
         for (genvar k = 0; k < DEC_USED; k++) begin : g_we
            assign dwe[k] = wr4 && (idx == IW'(FIX_WORDS + d * DEC_STRIDE + k));
         end
         memx_dec_slot #(
            .TGT_FULL (TGT_FULL)
         ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (dwe),
            .wdata (bus_wdata),
            .q     (dec_q[d])
         );
      end
   endgenerate

   // read map
   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_map
         if (w < FIX_WORDS) begin : g_f
            assign word_arr[w] = fix_q[w];
         end else if (w < DEC_END && ((w - FIX_WORDS) % DEC_STRIDE) < DEC_USED) begin : g_d
            assign word_arr[w] =
               dec_q[(w - FIX_WORDS) / DEC_STRIDE][(w - FIX_WORDS) % DEC_STRIDE];
         end else begin : g_z
            assign word_arr[w] = '0;
         end
      end
   endgenerate

   assign bus_rdata = rd4 ? word_arr[idx] : '0;

   AST_WIDE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_size == SZ_W8) |=> $stable(fix_q[W_GCTL])); // R1

   AST_CAP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(fix_q[W_CAP])); // R8

endmodule

// File: tb/memx_regfile_test.sv
module memx_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [1:0]  bus_size = 2'b10;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_dev, rd_sw;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] mdl    [64];
   logic [31:0] mdl_sw [64];

   always #5 clk = ~clk;

   memx_regfile #(.ADDR_W(8), .NUM_DEC(4), .TGT_FULL(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rd_dev));

   memx_regfile #(.ADDR_W(8), .NUM_DEC(4), .TGT_FULL(1'b1)) uut_sw (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rd_sw));

   // R10 map, R4..R8 reset values
   function automatic logic [31:0] exp_reset(input int w);
      case (w)
         0:    return 32'h312;
         3, 4: return 32'h1CFFF;
         6:    return 32'h7F;
         7:    return 32'h200;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_mask(input int w, input bit sw);
      if (w == 1) return 32'h3;
      if (w >= 2 && w <= 4) return 32'h1CFFF;
      if (w == 5 || w == 6) return 32'h7F;
      if (w >= 8 && w < 40) begin
         case ((w - 8) % 8)
            0, 2:    return 32'hF000_0000;
            1, 3, 6: return 32'hFFFF_FFFF;
            4:       return 32'h13FF;
            5:       return sw ? 32'hFFFF_FFFF : 32'hF000_0000;
            default: return 32'h0;
         endcase
      end
      return 32'h0;
   endfunction

   function automatic string tag_of(input int w);
      if (w == 0) return "R8";
      if (w == 1) return "R6";
      if (w < 8)  return "R7";
      if (w < 40) begin
         case ((w - 8) % 8)
            0, 1, 2, 3: return "R4";
            4:          return "R3";
            5, 6:       return "R5";
            default:    return "R9";
         endcase
      end
      return "R9";
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                         input int w, input bit sw);
      logic [31:0] m, v;
      m = exp_mask(w, sw);
      v = (d & m) | (old & ~m);   // R2
      if (w >= 8 && w < 40 && (w - 8) % 8 == 4) begin
         v[10] = v[9];            // R3
         v[11] = 1'b0;
      end
      return v;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic bus_wr(input int w, input logic [31:0] d, input bit wide);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1;
      bus_size  = wide ? 2'b11 : 2'b10;
      bus_addr  = 8'(w * 4);
      bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'b10;
      if (!wide) begin
         mdl[w]    = merge(mdl[w], d, w, 1'b0);
         mdl_sw[w] = merge(mdl_sw[w], d, w, 1'b1);
      end
   endtask

   task automatic bus_rd(input int w, input bit wide);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0;
      bus_size  = wide ? 2'b11 : 2'b10;
      bus_addr  = 8'(w * 4);
      #1;
   endtask

   task automatic sweep(input string phase);
      for (int w = 0; w < 64; w++) begin
         bus_rd(w, 1'b0);
         check(tag_of(w), $sformatf("%s dev word %0d", phase, w), rd_dev, mdl[w]);
         check(tag_of(w), $sformatf("%s sw word %0d", phase, w), rd_sw, mdl_sw[w]);
      end
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      for (int w = 0; w < 64; w++) begin
         mdl[w] = exp_reset(w);
         mdl_sw[w] = exp_reset(w);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state, R7 R8 R10
      sweep("reset");
      // idle bus reads zero, R1
      @(negedge clk);
      check("R1", "idle rdata", rd_dev, 32'h0);

      // R2: all ones then all zeros then a pattern into every word, R9 unmapped included
      for (int w = 0; w < 64; w++) bus_wr(w, 32'hFFFF_FFFF, 1'b0);
      sweep("ones");
      for (int w = 0; w < 64; w++) bus_wr(w, 32'h0, 1'b0);
      sweep("zeros");
      for (int w = 0; w < 64; w++) bus_wr(w, 32'hA5C3_5A3C ^ 32'(w * 32'h0101_0101), 1'b0);
      sweep("pattern");

      // R3: commit and uncommit on every decoder
      for (int d = 0; d < 4; d++) begin
         int cw;
         cw = 8 + 8 * d + 4;
         bus_wr(cw, 32'h0000_0A05, 1'b0);
         bus_rd(cw, 1'b0);
         check("R3", $sformatf("commit dec %0d", d), rd_dev, 32'h0000_0605);
         bus_wr(cw, 32'h0000_0C05, 1'b0);
         bus_rd(cw, 1'b0);
         check("R3", $sformatf("uncommit dec %0d", d), rd_dev, 32'h0000_0005);
         bus_wr(cw, 32'hFFFF_FFFF, 1'b0);
         bus_rd(cw, 1'b0);
         check("R3", $sformatf("ones dec %0d", d), rd_dev, 32'h0000_17FF);
      end

      // R1: 8-byte writes change nothing, 8-byte reads return zero
      for (int w = 0; w < 64; w++) bus_wr(w, (w % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF, 1'b1);
      sweep("wide-write");
      bus_rd(0, 1'b1);
      check("R1", "wide read cap", rd_dev, 32'h0);
      bus_rd(12, 1'b1);
      check("R1", "wide read ctrl", rd_dev, 32'h0);

      // R6 global control narrow pattern
      bus_wr(1, 32'h0000_0006, 1'b0);
      bus_rd(1, 1'b0);
      check("R6", "global ctrl merge", rd_dev, 32'h0000_0002);

      done = 1'b1;
      finish_run();
   end

endmodule